// File: doc/BRIEF.md
# Wakeup and Tree-Select Issue Queue

This block is an instruction issue queue for an out-of-order core. It has sixteen slots. Each slot holds a destination tag and two source tags, and each source tag has a ready flag. In every cycle, up to four result tags arrive on broadcast buses. Every waiting source compares its tag with every valid bus. When a tag matches, that source becomes ready at the next clock edge. A slot whose two sources are both ready raises an issue request.

Two identical execution units take work from the queue. A selector built as a tree of four-request arbiter cells picks the lowest-indexed requesting slot for unit 0. A second selector of the same shape looks at the remaining requests, with the first grant removed, and picks the next slot for unit 1. Each granted slot sends out its destination tag and is freed at the following edge.

New work arrives one entry per cycle and goes into the lowest-indexed free slot. If a broadcast carries a source's tag in the same cycle that the entry is dispatched, that source enters the queue already ready.

Top module: `wakeup_select_rs`

## Requirements
- R1: While reset is held and at the first cycle after it, no slot is occupied: both issue valids are 0 and `rs_full` is 0.
- R2: When a valid broadcast bus carries the tag of a waiting source in a held slot, that source becomes ready at the clock edge. The slot can be granted from the next cycle on.
- R3: A slot is granted only when it is occupied and both of its sources are ready. A slot with one ready source never issues.
- R4: Issue port 0 is valid whenever at least one slot requests. It carries the destination tag of the lowest-indexed requesting slot. Slot 0 has the highest priority.
- R5: Issue port 1 is valid only when two or more slots request. It carries the destination tag of the lowest-indexed requesting slot other than the one granted on port 0. The two ports never grant the same slot.
- R6: A slot granted in a cycle is empty after the next edge. Its tag is never issued again unless it is dispatched again.
- R7: An accepted dispatch is written into the lowest-indexed slot that is free at the start of the cycle. Each source's ready flag is the dispatched ready bit ORed with a match against any valid bus in that same cycle.
- R8: `rs_full` is 1 exactly when all slots are occupied. A dispatch while `rs_full` is 1 is dropped. A slot freed by an issue in the same cycle is not reused until the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request for one new entry |
| disp_src0_tag | input | 6 | First source tag |
| disp_src0_rdy | input | 1 | First source already available |
| disp_src1_tag | input | 6 | Second source tag |
| disp_src1_rdy | input | 1 | Second source already available |
| disp_dst_tag | input | 6 | Destination tag of the new entry |
| bc_valid | input | 4 | Per-bus broadcast valid |
| bc_tags | input | 24 | Broadcast tags, bus b in bits [6b+5:6b] |
| iss0_valid | output | 1 | Unit 0 issue valid |
| iss0_tag | output | 6 | Unit 0 destination tag |
| iss1_valid | output | 1 | Unit 1 issue valid |
| iss1_tag | output | 6 | Unit 1 destination tag |
| rs_full | output | 1 | All slots occupied |

## Verification
A lost or spurious ready flag shows up at the issue ports one cycle after the broadcast that should have woken the slot. A wrong entry issues early, or an expected tag is missing, or is late compared with the bench model. A slot that is not freed issues its tag a second time on the very next cycle. A wrong choice of free slot changes the order of later grants, and that shows up as a tag mismatch on port 0 or port 1. Because the bench compares both ports and the full flag in every cycle, most faults show up within one or two cycles of their cause.

// File: rtl/wakeup_select_rs.sv
module wakeup_select_rs #(
  parameter int ENTRIES = 16,
  parameter int TAGW    = 6,
  parameter int NBUS    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 disp_valid,
  input  logic [TAGW-1:0]      disp_src0_tag,
  input  logic                 disp_src0_rdy,
  input  logic [TAGW-1:0]      disp_src1_tag,
  input  logic                 disp_src1_rdy,
  input  logic [TAGW-1:0]      disp_dst_tag,
  input  logic [NBUS-1:0]      bc_valid,
  input  logic [NBUS*TAGW-1:0] bc_tags,
  output logic                 iss0_valid,
  output logic [TAGW-1:0]      iss0_tag,
  output logic                 iss1_valid,
  output logic [TAGW-1:0]      iss1_tag,
  output logic                 rs_full
);
  // Two-level tree: ENTRIES must be a multiple of 4 and at most 16.
  localparam int LEAVES = ENTRIES / 4;
  localparam int IDXW   = $clog2(ENTRIES);

  logic [ENTRIES-1:0] valid_q, rdy0_q, rdy1_q;
  logic [TAGW-1:0]    tag0_q [ENTRIES];
  logic [TAGW-1:0]    tag1_q [ENTRIES];
  logic [TAGW-1:0]    dst_q  [ENTRIES];

  logic [ENTRIES-1:0] req, grant0, grant1, grant_any, alloc_we;
  logic [IDXW-1:0]    alloc_idx;
  logic               have_free;

  function automatic logic bus_hit(input logic [TAGW-1:0] t,
                                   input logic [NBUS-1:0] bv,
                                   input logic [NBUS*TAGW-1:0] bt);
    logic h;
    h = 1'b0;
    for (int b = 0; b < NBUS; b++)
      if (bv[b] && bt[b*TAGW +: TAGW] == t) h = 1'b1;
    return h;
  endfunction

  // {any_request, grant[3:0]}: lowest requester wins when enabled
  function automatic logic [4:0] arb4(input logic [3:0] r, input logic en);
    logic [3:0] g;
    g = '0;
    if (en) begin
      if      (r[0]) g[0] = 1'b1;
      else if (r[1]) g[1] = 1'b1;
      else if (r[2]) g[2] = 1'b1;
      else if (r[3]) g[3] = 1'b1;
    end
    return {|r, g};
  endfunction

  function automatic logic [ENTRIES-1:0] tree_select(input logic [ENTRIES-1:0] r);
    logic [3:0] root_req;
    logic [4:0] rc, lc;
    logic [ENTRIES-1:0] g;
    root_req = '0;
    g = '0;
    for (int l = 0; l < LEAVES; l++) begin
      lc = arb4(r[4*l +: 4], 1'b0);
      root_req[l] = lc[4];
    end
    rc = arb4(root_req, 1'b1);
    for (int l = 0; l < LEAVES; l++) begin
      lc = arb4(r[4*l +: 4], rc[l]);
      g[4*l +: 4] = lc[3:0];
    end
    return g;
  endfunction

  assign req       = valid_q & rdy0_q & rdy1_q;
  assign grant0    = tree_select(req);
  assign grant1    = tree_select(req & ~grant0);
  assign grant_any = grant0 | grant1;
  assign rs_full   = &valid_q;

  always_comb begin
    have_free = 1'b0;
    alloc_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!valid_q[i]) begin
        have_free = 1'b1;
        alloc_idx = IDXW'(i);
      end
  end

  always_comb begin
    alloc_we = '0;
    if (disp_valid && have_free) alloc_we[alloc_idx] = 1'b1;
  end

  always_comb begin
    iss0_tag = '0;
    iss1_tag = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (grant0[i]) iss0_tag = iss0_tag | dst_q[i];
      if (grant1[i]) iss1_tag = iss1_tag | dst_q[i];
    end
  end

  assign iss0_valid = |grant0;
  assign iss1_valid = |grant1;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
        rdy0_q[i]  <= 1'b0;
        rdy1_q[i]  <= 1'b0;
        tag0_q[i]  <= '0;
        tag1_q[i]  <= '0;
        dst_q[i]   <= '0;
      end else if (grant_any[i]) begin
        valid_q[i] <= 1'b0;
      end else if (alloc_we[i]) begin
        valid_q[i] <= 1'b1;
        tag0_q[i]  <= disp_src0_tag;
        tag1_q[i]  <= disp_src1_tag;
        dst_q[i]   <= disp_dst_tag;
        rdy0_q[i]  <= disp_src0_rdy | bus_hit(disp_src0_tag, bc_valid, bc_tags);
        rdy1_q[i]  <= disp_src1_rdy | bus_hit(disp_src1_tag, bc_valid, bc_tags);
      end else if (valid_q[i]) begin
        rdy0_q[i]  <= rdy0_q[i] | bus_hit(tag0_q[i], bc_valid, bc_tags);
        rdy1_q[i]  <= rdy1_q[i] | bus_hit(tag1_q[i], bc_valid, bc_tags);
      end
    end
  end
endmodule

module wakeup_select_rs_chk #(
  parameter int ENTRIES = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic [ENTRIES-1:0] valid_q,
  input logic [ENTRIES-1:0] req,
  input logic [ENTRIES-1:0] grant0,
  input logic [ENTRIES-1:0] grant1,
  input logic               iss0_valid,
  input logic               iss1_valid,
  input logic               rs_full
);
  AST_G0_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant0)); // R4
  AST_G1_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant1)); // R5
  AST_PORTS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (grant0 & grant1) == '0); // R5
  AST_PORT1_NEEDS_PORT0: assert property (@(posedge clk) disable iff (!rst_n)
    iss1_valid |-> iss0_valid); // R5
  AST_GRANT_ONLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant0 | grant1) & ~req) == '0); // R3
  AST_GRANT_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    |(grant0 | grant1) |=> (valid_q & $past(grant0 | grant1)) == '0); // R6
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rs_full && !iss0_valid) |=> rs_full); // R8
endmodule

bind wakeup_select_rs wakeup_select_rs_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_q(valid_q), .req(req),
  .grant0(grant0), .grant1(grant1), .iss0_valid(iss0_valid),
  .iss1_valid(iss1_valid), .rs_full(rs_full));

// File: tb/sim_wakeup_select_rs.sv
`timescale 1ns/1ps
module sim_wakeup_select_rs;
  localparam int N = 16, TW = 6, NB = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic disp_valid = 1'b0, disp_src0_rdy = 1'b0, disp_src1_rdy = 1'b0;
  logic [TW-1:0] disp_src0_tag = '0, disp_src1_tag = '0, disp_dst_tag = '0;
  logic [NB-1:0] bc_valid = '0;
  logic [NB*TW-1:0] bc_tags = '0;
  logic iss0_valid, iss1_valid, rs_full;
  logic [TW-1:0] iss0_tag, iss1_tag;

  int checks = 0, errors = 0;
  bit m_v [N], m_r0 [N], m_r1 [N];
  logic [TW-1:0] m_t0 [N], m_t1 [N], m_d [N];

  always #4 clk = ~clk;

  wakeup_select_rs u0 (.*);

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", rq, act, exp, $time);
    end
  endtask

  function automatic bit hit(input logic [TW-1:0] t, input logic [NB-1:0] bv,
                             input logic [NB*TW-1:0] bt);
    for (int b = 0; b < NB; b++) if (bv[b] && bt[b*TW +: TW] == t) return 1'b1;
    return 1'b0;
  endfunction

  task automatic step(input bit dv, input logic [TW-1:0] t0, input bit r0,
                      input logic [TW-1:0] t1, input bit r1, input logic [TW-1:0] d,
                      input logic [NB-1:0] bv, input logic [NB*TW-1:0] bt);
    int e0, e1, fr;
    bit full;
    @(negedge clk);
    disp_valid = dv; disp_src0_tag = t0; disp_src0_rdy = r0;
    disp_src1_tag = t1; disp_src1_rdy = r1; disp_dst_tag = d;
    bc_valid = bv; bc_tags = bt;
    #1;
    e0 = -1; e1 = -1; fr = -1; full = 1'b1;
    for (int i = 0; i < N; i++) begin
      if (m_v[i] && m_r0[i] && m_r1[i]) begin
        if (e0 < 0) e0 = i; else if (e1 < 0) e1 = i;
      end
      if (!m_v[i]) begin full = 1'b0; if (fr < 0) fr = i; end
    end
    check(iss0_valid == (e0 >= 0), "R4 iss0_valid", iss0_valid, e0 >= 0);
    if (e0 >= 0) check(iss0_tag == m_d[e0], "R4 iss0_tag", iss0_tag, m_d[e0]);
    check(iss1_valid == (e1 >= 0), "R5 iss1_valid", iss1_valid, e1 >= 0);
    if (e1 >= 0) check(iss1_tag == m_d[e1], "R5 iss1_tag", iss1_tag, m_d[e1]);
    check(rs_full == full, "R8 rs_full", rs_full, full);
    // model next state: R2 wake, R6 free, R7 alloc
    for (int i = 0; i < N; i++)
      if (m_v[i]) begin
        m_r0[i] = m_r0[i] | hit(m_t0[i], bv, bt);
        m_r1[i] = m_r1[i] | hit(m_t1[i], bv, bt);
      end
    if (e0 >= 0) m_v[e0] = 1'b0;
    if (e1 >= 0) m_v[e1] = 1'b0;
    if (dv && fr >= 0) begin
      m_v[fr] = 1'b1; m_t0[fr] = t0; m_t1[fr] = t1; m_d[fr] = d;
      m_r0[fr] = r0 | hit(t0, bv, bt);
      m_r1[fr] = r1 | hit(t1, bv, bt);
    end
  endtask

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_r0[i] = 0; m_r1[i] = 0; end
    repeat (3) @(posedge clk);
    #1;
    check(!iss0_valid && !iss1_valid && !rs_full, "R1 reset outputs",
          {iss0_valid, iss1_valid, rs_full}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R7 + R2: dispatch with both sources woken by same-cycle broadcasts
    step(1, 6'd20, 0, 6'd21, 0, 6'd33, 4'b0101, {6'd0, 6'd21, 6'd0, 6'd20});
    step(0, 0, 0, 0, 0, 0, 0, 0);
    check(1'b1, "R7", 0, 0);

    // R3: one source stays unready, must not issue
    step(1, 6'd40, 1, 6'd41, 0, 6'd1, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 4'b1000, {6'd41, 18'd0});
    step(0, 0, 0, 0, 0, 0, 0, 0);

    // R8: fill all slots with waiting entries, then push one extra
    for (int k = 0; k < N; k++) step(1, 6'd63, 0, 6'd63, 1, 6'(k), 0, 0);
    step(1, 6'd0, 1, 6'd0, 1, 6'd50, 0, 0);
    step(1, 6'd0, 1, 6'd0, 1, 6'd51, 0, 0);
    // R2/R4/R5/R6: release everything; tags drain in pairs by slot index
    step(0, 0, 0, 0, 0, 0, 4'b0010, {12'd0, 6'd63, 6'd0});
    for (int k = 0; k < 12; k++) step(0, 0, 0, 0, 0, 0, 0, 0);

    // random traffic
    for (int k = 0; k < 3000; k++) begin
      logic [NB-1:0] bv;
      logic [NB*TW-1:0] bt;
      for (int b = 0; b < NB; b++) begin
        bv[b] = ($urandom_range(0, 3) == 0);
        bt[b*TW +: TW] = 6'($urandom_range(0, 15));
      end
      step($urandom_range(0, 1) == 1, 6'($urandom_range(0, 15)),
           $urandom_range(0, 3) == 0, 6'($urandom_range(0, 15)),
           $urandom_range(0, 3) == 0, 6'($urandom_range(0, 63)), bv, bt);
    end
    finish_run();
  end
endmodule